// File: doc/BRIEF.md
# Two-Wire Multi-Master Bus Monitor

This block watches the clock and data lines of an open-drain two-wire bus for a controller that can work as either a bus master or a listening slave. Each pin level passes through a two-flop synchroniser and a majority-free glitch filter. The filtered levels feed start and stop condition detectors, which keep a bus-busy indication. Busy is also dropped after a programmable stretch of idle cycles with both lines high.

Software sees a stop flag that stays set until it writes a one to clear it. This flag is a plain status bit and raises no interrupt. A live collision bit compares the top bit of the transmit shift register with the filtered data line.

A local request to act as master is granted only while the bus is idle. The block then stays in master mode until a stop condition ends the transfer. It drops back to master mode off early if it loses arbitration. Arbitration is lost when the local master releases data but finds it low at a clock rising edge. When that happens, both drive enables are forced off in the same cycle and an arbitration-lost flag is latched.

Top module: `twi_bus_monitor`

## Requirements
- R1: After reset, busy, stop flag, grant, master mode, arbitration-lost and both drive enables are all 0.
- R2: A filtered data falling edge while the filtered clock is high (START) sets busy.
- R3: A filtered data rising edge while the filtered clock is high (STOP) clears busy and sets the stop flag. A data change while the clock is low changes neither.
- R4: The stop flag holds until a cycle with the clear input at 1. A 0 on the clear input leaves it set.
- R5: The collision output is 1 exactly when the transmit MSB input differs from the filtered data level.
- R6: The grant output is 1 only while the start request is 1 and busy is 0.
- R7: A grant enters master mode. A detected STOP returns the block to slave mode, with master mode at 0.
- R8: In master mode, a clock rising edge with the transmit MSB at 1 and data low latches arbitration-lost. It also clears master mode and holds both drive enables at 0.
- R9: Outside master mode, or when data matches the transmit MSB, a clock rising edge leaves arbitration-lost at 0.
- R10: While busy, IDLE_CYC consecutive cycles with both filtered lines high clear busy without setting the stop flag.
- R11: A pin pulse shorter than FILT_LEN cycles does not change the filtered level, so it produces no START.
- R12: The arbitration-lost flag clears on a cycle with its clear input at 1.
- R13: In master mode without arbitration loss, each drive enable follows its drive request. Outside master mode, both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_pin_i | input | 1 | Sampled clock line level |
| sda_pin_i | input | 1 | Sampled data line level |
| tx_msb_i | input | 1 | MSB of the transmit shift register |
| start_req_i | input | 1 | Local master asks to start a transfer |
| sda_drv_req_i | input | 1 | Bit engine wants to pull data low |
| scl_drv_req_i | input | 1 | Bit engine wants to pull clock low |
| stop_clr_i | input | 1 | Write-one-to-clear strobe for the stop flag |
| arb_clr_i | input | 1 | Clear strobe for arbitration-lost |
| busy_o | output | 1 | Bus busy |
| stop_flag_o | output | 1 | Sticky STOP-seen status |
| coll_o | output | 1 | Transmit MSB differs from data line |
| grant_o | output | 1 | Local master may issue START |
| mst_mode_o | output | 1 | Block is acting as master |
| arb_lost_o | output | 1 | Arbitration lost, latched |
| sda_oe_o | output | 1 | Pull data line low |
| scl_oe_o | output | 1 | Pull clock line low |

## Verification
The hardest state to reach is a lost arbitration. It needs master mode granted on an idle bus, a START issued by the local master, a clock low phase, and then a clock rising edge where the local MSB is 1 but another master holds data low. The bench reaches it by driving both pins the way a competing master would, while holding the local transmit MSB high. The idle timeout is also awkward to reach. The bench gets there by raising data while the clock is low and then raising the clock, so both lines sit high on a busy bus without any STOP.

// File: rtl/twi_mon_pkg.sv
// Shared types for the two-wire bus monitor.
// Assumes: two lines only, clock and data, both active-high levels.
package twi_mon_pkg;
    typedef struct packed {
        logic scl;
        logic sda;
    } twi_lines_t;
endpackage

// File: rtl/twi_line_filter.sv
// Synchronises one bus line and filters out pulses shorter than FILT_LEN.
// Assumes: the pin idles high; the output only changes once FILT_LEN
// consecutive synchronised samples agree. Also outputs last cycle's level.
module twi_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic prev_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;

    // Metastability chain followed by the sample history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
        end
    end

    // Filtered level moves only when the whole history agrees.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_o <= 1'b1;
            prev_o  <= 1'b1;
        end else begin
            prev_o <= level_o;
            if (&hist_q)
                level_o <= 1'b1;
            else if (~|hist_q)
                level_o <= 1'b0;
        end
    end
endmodule

// File: rtl/twi_cond_detect.sv
// Detects START/STOP, keeps bus-busy with an idle timeout, and holds the
// write-one-to-clear stop flag (status only, no interrupt).
// Assumes: filtered line levels and previous data level as inputs.
module twi_cond_detect #(
    parameter int IDLE_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl_i,
    input  logic sda_lvl_i,
    input  logic sda_prev_i,
    input  logic stop_clr_i,
    output logic start_o,
    output logic stop_o,
    output logic busy_o,
    output logic stop_flag_o
);
    localparam int CW = $clog2(IDLE_CYC + 1);
    logic [CW-1:0] idle_cnt_q;

    // Conditions: data edge while clock is high.
    always_comb begin
        start_o = scl_lvl_i & sda_prev_i & ~sda_lvl_i;
        stop_o  = scl_lvl_i & ~sda_prev_i & sda_lvl_i;
    end

    // Busy tracking with idle timeout counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o     <= 1'b0;
            idle_cnt_q <= '0;
        end else if (start_o) begin
            busy_o     <= 1'b1;
            idle_cnt_q <= '0;
        end else if (stop_o) begin
            busy_o     <= 1'b0;
            idle_cnt_q <= '0;
        end else if (busy_o && scl_lvl_i && sda_lvl_i) begin
            if (idle_cnt_q == CW'(IDLE_CYC - 1)) begin
                busy_o     <= 1'b0;
                idle_cnt_q <= '0;
            end else begin
                idle_cnt_q <= idle_cnt_q + 1'b1;
            end
        end else begin
            idle_cnt_q <= '0;
        end
    end

    // Sticky stop flag; a new STOP wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stop_flag_o <= 1'b0;
        else if (stop_o)
            stop_flag_o <= 1'b1;
        else if (stop_clr_i)
            stop_flag_o <= 1'b0;
    end
endmodule

// File: rtl/twi_arb_ctrl.sv
// Master grant, master/slave mode, collision compare and arbitration loss.
// Assumes: the bit engine only requests drive after a grant; a loss cuts
// the drive enables in the detection cycle itself.
module twi_arb_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl_i,
    input  logic scl_prev_i,
    input  logic sda_lvl_i,
    input  logic tx_msb_i,
    input  logic busy_i,
    input  logic stop_i,
    input  logic start_req_i,
    input  logic sda_drv_req_i,
    input  logic scl_drv_req_i,
    input  logic arb_clr_i,
    output logic grant_o,
    output logic mst_mode_o,
    output logic arb_lost_o,
    output logic coll_o,
    output logic sda_oe_o,
    output logic scl_oe_o
);
    logic scl_rise;
    logic lose_now;

    // Grant, collision and loss detection; drive gating.
    always_comb begin
        scl_rise = scl_lvl_i & ~scl_prev_i;
        grant_o  = start_req_i & ~busy_i;
        coll_o   = tx_msb_i ^ sda_lvl_i;
        lose_now = mst_mode_o & scl_rise & tx_msb_i & ~sda_lvl_i;
        sda_oe_o = sda_drv_req_i & mst_mode_o & ~lose_now;
        scl_oe_o = scl_drv_req_i & mst_mode_o & ~lose_now;
    end

    // Master mode: entered on grant, left on STOP or loss.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mst_mode_o <= 1'b0;
        else if (lose_now || stop_i)
            mst_mode_o <= 1'b0;
        else if (grant_o)
            mst_mode_o <= 1'b1;
    end

    // Latched arbitration-lost flag with explicit clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            arb_lost_o <= 1'b0;
        else if (lose_now)
            arb_lost_o <= 1'b1;
        else if (arb_clr_i)
            arb_lost_o <= 1'b0;
    end
endmodule

// File: rtl/twi_bus_monitor.sv
// Top level: two filtered lines, condition detector and arbitration control.
// Assumes: pins are open-drain; oe outputs pull the line low when 1.
module twi_bus_monitor #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3,
    parameter int IDLE_CYC    = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_pin_i,
    input  logic sda_pin_i,
    input  logic tx_msb_i,
    input  logic start_req_i,
    input  logic sda_drv_req_i,
    input  logic scl_drv_req_i,
    input  logic stop_clr_i,
    input  logic arb_clr_i,
    output logic busy_o,
    output logic stop_flag_o,
    output logic coll_o,
    output logic grant_o,
    output logic mst_mode_o,
    output logic arb_lost_o,
    output logic sda_oe_o,
    output logic scl_oe_o
);
    import twi_mon_pkg::*;

    twi_lines_t lvl;
    twi_lines_t prv;
    logic       start_det;
    logic       stop_det;

    twi_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .pin_i(scl_pin_i),
        .level_o(lvl.scl), .prev_o(prv.scl)
    );

    twi_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .pin_i(sda_pin_i),
        .level_o(lvl.sda), .prev_o(prv.sda)
    );

    twi_cond_detect #(.IDLE_CYC(IDLE_CYC)) u_cond (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl_i(lvl.scl), .sda_lvl_i(lvl.sda), .sda_prev_i(prv.sda),
        .stop_clr_i(stop_clr_i),
        .start_o(start_det), .stop_o(stop_det),
        .busy_o(busy_o), .stop_flag_o(stop_flag_o)
    );

    twi_arb_ctrl u_arb (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl_i(lvl.scl), .scl_prev_i(prv.scl), .sda_lvl_i(lvl.sda),
        .tx_msb_i(tx_msb_i), .busy_i(busy_o), .stop_i(stop_det),
        .start_req_i(start_req_i), .sda_drv_req_i(sda_drv_req_i),
        .scl_drv_req_i(scl_drv_req_i), .arb_clr_i(arb_clr_i),
        .grant_o(grant_o), .mst_mode_o(mst_mode_o), .arb_lost_o(arb_lost_o),
        .coll_o(coll_o), .sda_oe_o(sda_oe_o), .scl_oe_o(scl_oe_o)
    );
endmodule

// File: rtl/twi_bus_monitor_chk.sv
// Checker for twi_bus_monitor: temporal properties on ports and the
// internal START/STOP pulses. Attached by bind below.
module twi_bus_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic start_det,
    input logic stop_det,
    input logic busy_o,
    input logic stop_flag_o,
    input logic stop_clr_i,
    input logic grant_o,
    input logic mst_mode_o,
    input logic arb_lost_o,
    input logic sda_oe_o,
    input logic scl_oe_o
);
    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> busy_o);

    a_r3_stop_frees_bus: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!busy_o && stop_flag_o));

    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_flag_o && !stop_clr_i) |=> stop_flag_o);

    a_r7_grant_to_master: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && !mst_mode_o && !stop_det) |=> mst_mode_o);

    a_r7_stop_to_slave: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !mst_mode_o);

    a_r8_loss_leaves_master: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost_o) |-> !mst_mode_o);

    a_r8_loss_cuts_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost_o) |-> (!sda_oe_o && !scl_oe_o));

    a_r13_drive_only_master: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o || scl_oe_o) |-> mst_mode_o);
endmodule

bind twi_bus_monitor twi_bus_monitor_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .busy_o(busy_o), .stop_flag_o(stop_flag_o), .stop_clr_i(stop_clr_i),
    .grant_o(grant_o), .mst_mode_o(mst_mode_o), .arb_lost_o(arb_lost_o),
    .sda_oe_o(sda_oe_o), .scl_oe_o(scl_oe_o)
);

// File: tb/tb_twi_bus_monitor.sv
module tb_twi_bus_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1, tx = 1'b1, req = 1'b0;
    logic sdrv = 1'b0, cdrv = 1'b0, sclr = 1'b0, aclr = 1'b0;
    logic busy, stopf, coll, grant, mst, alost, sda_oe, scl_oe;
    int   n_chk = 0;
    int   n_bad = 0;

    always #4 clk = ~clk;

    twi_bus_monitor dut (
        .clk(clk), .rst_n(rst_n), .scl_pin_i(scl), .sda_pin_i(sda),
        .tx_msb_i(tx), .start_req_i(req), .sda_drv_req_i(sdrv),
        .scl_drv_req_i(cdrv), .stop_clr_i(sclr), .arb_clr_i(aclr),
        .busy_o(busy), .stop_flag_o(stopf), .coll_o(coll), .grant_o(grant),
        .mst_mode_o(mst), .arb_lost_o(alost), .sda_oe_o(sda_oe),
        .scl_oe_o(scl_oe)
    );

    // {scl, sda, req, tx} -> expected {busy, stopf, grant, mst}; coll derived.
    localparam logic [7:0] VEC [14] = '{
        8'b1101_0000, 8'b1001_1000, 8'b0001_1000, 8'b0101_1000,
        8'b1101_1000, 8'b0101_1000, 8'b0001_1000, 8'b1001_1000,
        8'b1101_0100, 8'b1111_0111, 8'b1011_1101, 8'b0001_1101,
        8'b1000_1101, 8'b1100_0100
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        wait_cyc(3);
        // R1 reset state
        chk("R1 busy", busy, 1'b0);
        chk("R1 stopf", stopf, 1'b0);
        chk("R1 mst", mst, 1'b0);
        chk("R1 arb_lost", alost, 1'b0);
        chk("R1 oe", sda_oe | scl_oe, 1'b0);
        rst_n = 1'b1;
        wait_cyc(2);

        // Table walk: R2,R3,R5,R6,R7
        for (int i = 0; i < 14; i++) begin
            {scl, sda, req, tx} = VEC[i][7:4];
            wait_cyc(12);
            chk($sformatf("R2,R3 busy step %0d", i), busy, VEC[i][3]);
            chk($sformatf("R3,R4 stopf step %0d", i), stopf, VEC[i][2]);
            chk($sformatf("R6 grant step %0d", i), grant, VEC[i][1]);
            chk($sformatf("R7 mst step %0d", i), mst, VEC[i][0]);
            chk($sformatf("R5 coll step %0d", i), coll, tx ^ sda);
        end

        // R4: clear with 0 keeps flag, write one clears it
        sclr = 1'b0; wait_cyc(3);
        chk("R4 hold", stopf, 1'b1);
        sclr = 1'b1; wait_cyc(1); sclr = 1'b0; wait_cyc(1);
        chk("R4 clear", stopf, 1'b0);

        // R13 and R8: become master, drive, then lose arbitration
        req = 1'b1; tx = 1'b1; wait_cyc(2);
        chk("R7 granted", mst, 1'b1);
        req = 1'b0; sdrv = 1'b1; cdrv = 1'b1; wait_cyc(1);
        chk("R13 sda_oe", sda_oe, 1'b1);
        chk("R13 scl_oe", scl_oe, 1'b1);
        sdrv = 1'b0; cdrv = 1'b0;
        sda = 1'b0; wait_cyc(12);
        chk("R2 own start busy", busy, 1'b1);
        scl = 1'b0; wait_cyc(12);
        cdrv = 1'b1;
        scl = 1'b1; wait_cyc(12);
        chk("R8 arb_lost", alost, 1'b1);
        chk("R8 mst cleared", mst, 1'b0);
        chk("R8 scl_oe off", scl_oe, 1'b0);
        cdrv = 1'b0;
        req = 1'b1; wait_cyc(1);
        chk("R6 no grant busy", grant, 1'b0);
        req = 1'b0;
        aclr = 1'b1; wait_cyc(1); aclr = 1'b0; wait_cyc(1);
        chk("R12 arb clear", alost, 1'b0);

        // R9: clock rise with mismatch but not master
        scl = 1'b0; wait_cyc(12);
        scl = 1'b1; wait_cyc(12);
        chk("R9 no loss as slave", alost, 1'b0);

        // R10: both high via clock-low data rise, no STOP
        scl = 1'b0; wait_cyc(12);
        sda = 1'b1; wait_cyc(12);
        scl = 1'b1; wait_cyc(20);
        chk("R10 still busy", busy, 1'b1);
        wait_cyc(70);
        chk("R10 timeout", busy, 1'b0);
        chk("R10 no stop flag", stopf, 1'b0);

        // R11: 2-cycle data glitch while clock high
        sda = 1'b0; wait_cyc(2); sda = 1'b1; wait_cyc(12);
        chk("R11 glitch ignored", busy, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule